// File: doc/BRIEF.md
# Static Key Matrix Event Detector

This block observes a grid of key switches whose row and column lines are read as steady levels. No line is ever driven in a scanning pattern, so the inputs toggle only when a switch actually moves. Each key passes through a two-stage synchronizer and its own debounce counter. The counter advances on a slow timebase strobe, and its length comes from a debounce field. Once a key settles in a new state, the block raises a pending flag for it. A priority picker turns the pending flags into a stream of encoded events, one per clock, which a downstream event FIFO receives.

The event stream carries a key number, a release flag and a valid strobe. Release events can be suppressed by a configuration bit. Autorepeat can also be enabled. It follows the key pressed most recently and emits further press events for it, first after an initial delay and then at a steady rate. Both the delay and the rate are counted in timebase ticks.

Top module: `static_keymatrix_detector`

## Requirements
- R1: Input bit `matLevel[r*COLS + c]` is the level at row r, column c (1 = closed). Its events carry key number `c*ROWS + r` on `evtCode`.
- R2: A key's settled state changes only on a `tick`, and only on the Nth consecutive tick at which its synchronized level differs from the settled state. N is `debounceTicks`, with 0 treated as 1. If the level matches the settled state for any clock in between, the count restarts.
- R3: A settled 0→1 change gives one event with `evtRelease`=0. A settled 1→0 change gives one event with `evtRelease`=1 only if `releaseEn` is 1 on the tick where the change settles; otherwise it gives nothing.
- R4: Events are presented one per clock while any are pending. Key changes from the same tick come out in ascending key number, back to back.
- R5: The first event caused by a tick is valid right after the first rising edge that follows the edge sampling `tick`. Consecutive events follow on consecutive clocks. `evtValid` is low whenever nothing is pending.
- R6: A press reported while `repeatEn`=1 arms autorepeat for that key. It then emits a press event for that key after `repeatDelay` further ticks, and after every `repeatRate` ticks from then on (0 in either field means 1). A repeat from a tick comes out after that tick's key-change events.
- R7: Autorepeat stops when its key settles released (whether or not releases are reported) or when a tick sees `repeatEn`=0. Any newer reported press retargets autorepeat, restarts the delay and drops a repeat from the same tick that has not yet come out.
- R8: While `rstN` is low and after reset, all keys count as released, nothing is pending and `evtValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| matLevel | input | ROWS*COLS | Static matrix levels, row-major, 1 = closed |
| tick | input | 1 | One-clock strobe from the slow timebase |
| debounceTicks | input | DEB_W | Debounce window in ticks |
| releaseEn | input | 1 | Report release events when 1 |
| repeatEn | input | 1 | Enable autorepeat |
| repeatDelay | input | REP_W | Ticks before the first repeat |
| repeatRate | input | REP_W | Ticks between later repeats |
| evtValid | output | 1 | Event strobe toward the event FIFO |
| evtCode | output | $clog2(ROWS*COLS) | Key number of the event |
| evtRelease | output | 1 | 1 for a release event, 0 for a press |

## Verification
The bench sweeps every row and column position. A transposed or row-major key code would then show up as a wrong `evtCode` on some key. It bounces a key back to its settled level partway through a window and uses a zero debounce field, which exposes a counter that is never cleared or a window that is off by one tick. A mask that flips every line at once checks that each event leaves on its expected clock and in ascending order; a picker that is reversed or drops events fails here. The autorepeat runs cover held keys, retargeting to a newer and lower-numbered key, release while `releaseEn` is off, and disabling mid-hold. A timer that is one tick off, keeps firing after release, or re-arms on its own repeats would emit extra, missing or misplaced press events.

// File: rtl/keymx_pkg.sv
package keymx_pkg;

  typedef enum logic {
    PH_DELAY = 1'b0,
    PH_RATE  = 1'b1
  } repPhase_t;

  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic pop;         // consume the event the picker offers
    logic popRelease;  // the consumed event is a release
  } popStrobe_t;

endpackage

// File: rtl/keymx_debounce_cell.sv
module keymx_debounce_cell #(
  parameter int DEB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic             tick,
  input  logic [DEB_W:0]   debLimit,
  output logic             lvlOut,
  output logic             stableOut,
  output logic             flipOut
);

  logic             lvl;
  logic             stableQ;
  logic [DEB_W-1:0] cntQ;
  logic [DEB_W:0]   cntInc;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign lvl = rawIn;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncQ <= '0;
        end else begin
          syncQ[0] <= rawIn;
          for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
        end
      end
      assign lvl = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  assign cntInc  = {1'b0, cntQ} + (DEB_W+1)'(1);
  assign flipOut = tick && (lvl != stableQ) && (cntInc >= debLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stableQ <= 1'b0;
      cntQ    <= '0;
    end else if (lvl == stableQ) begin
      cntQ <= '0;
    end else if (tick) begin
      if (flipOut) begin
        stableQ <= lvl;
        cntQ    <= '0;
      end else begin
        cntQ <= cntInc[DEB_W-1:0];
      end
    end
  end

  assign lvlOut    = lvl;
  assign stableOut = stableQ;

endmodule

// File: rtl/keymx_datapath.sv
module keymx_datapath
  import keymx_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int COLS        = 8,
  parameter int DEB_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NKEYS      = ROWS * COLS,
  localparam int KEY_W      = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NKEYS-1:0] matLevel,
  input  logic             tick,
  input  logic [DEB_W-1:0] debounceTicks,
  input  logic             releaseEn,
  input  popStrobe_t       strobe,
  output logic [NKEYS-1:0] stableVec,
  output logic [NKEYS-1:0] stableNext,
  output logic             pendAny,
  output logic [KEY_W-1:0] pendKey,
  output logic             pendRelease
);

  logic [DEB_W:0]   debLimit;
  logic [NKEYS-1:0] lvlVec;
  logic [NKEYS-1:0] flipVec;
  logic [NKEYS-1:0] pendPress, pendRel;
  logic [NKEYS-1:0] setPress, setRel;
  logic [NKEYS-1:0] clrPress, clrRel;

  assign debLimit = (debounceTicks == '0) ? (DEB_W+1)'(1) : {1'b0, debounceTicks};

  // Key number is column-major: c*ROWS + r; the input is row-major.
  genvar c, r;
  generate
    for (c = 0; c < COLS; c++) begin : g_col
      for (r = 0; r < ROWS; r++) begin : g_row
        localparam int KEY = c * ROWS + r;
        localparam int BIT = r * COLS + c;
        keymx_debounce_cell #(
          .DEB_W      (DEB_W),
          .SYNC_STAGES(SYNC_STAGES)
        ) u_cell (
          .clk      (clk),
          .rstN     (rstN),
          .rawIn    (matLevel[BIT]),
          .tick     (tick),
          .debLimit (debLimit),
          .lvlOut   (lvlVec[KEY]),
          .stableOut(stableVec[KEY]),
          .flipOut  (flipVec[KEY])
        );
      end
    end
  endgenerate

  assign stableNext = (stableVec & ~flipVec) | (lvlVec & flipVec);
  assign setPress   = flipVec & lvlVec;
  assign setRel     = flipVec & ~lvlVec & {NKEYS{releaseEn}};

  always_comb begin
    clrPress = '0;
    clrRel   = '0;
    if (strobe.pop) begin
      if (strobe.popRelease) clrRel[pendKey]   = 1'b1;
      else                   clrPress[pendKey] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPress <= '0;
      pendRel   <= '0;
    end else begin
      pendPress <= (pendPress & ~clrPress) | setPress;
      pendRel   <= (pendRel & ~clrRel) | setRel;
    end
  end

  // Lowest key number wins; a press goes before a release of the same key.
  always_comb begin
    pendAny     = 1'b0;
    pendKey     = '0;
    pendRelease = 1'b0;
    for (int k = NKEYS - 1; k >= 0; k--) begin
      if (pendPress[k] || pendRel[k]) begin
        pendAny     = 1'b1;
        pendKey     = KEY_W'(k);
        pendRelease = !pendPress[k];
      end
    end
  end

endmodule

// File: rtl/keymx_control.sv
module keymx_control
  import keymx_pkg::*;
#(
  parameter int NKEYS  = 64,
  parameter int REP_W  = 4,
  localparam int KEY_W = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             repeatEn,
  input  logic [REP_W-1:0] repeatDelay,
  input  logic [REP_W-1:0] repeatRate,
  input  logic             pendAny,
  input  logic [KEY_W-1:0] pendKey,
  input  logic             pendRelease,
  input  logic [NKEYS-1:0] stableNext,
  output popStrobe_t       strobe,
  output logic             evtValid,
  output logic [KEY_W-1:0] evtCode,
  output logic             evtRelease,
  output logic             repPending
);

  logic             repActive;
  logic             repPend;
  logic [KEY_W-1:0] repKey;
  logic [KEY_W-1:0] lastKey;
  logic [REP_W-1:0] repCnt;
  repPhase_t        phase;
  logic [REP_W:0]   curLimit;
  logic [REP_W:0]   repInc;
  logic             repStop;
  logic             repFire;
  logic             armNow;
  logic             emitRep;

  assign strobe.pop        = pendAny;
  assign strobe.popRelease = pendRelease;

  always_comb begin
    curLimit = (phase == PH_RATE) ? {1'b0, repeatRate} : {1'b0, repeatDelay};
    if (curLimit == '0) curLimit = (REP_W+1)'(1);
  end

  assign repInc  = {1'b0, repCnt} + (REP_W+1)'(1);
  assign repStop = tick && repActive && (!repeatEn || !stableNext[lastKey]);
  assign repFire = tick && repActive && !repStop && (repInc >= curLimit);
  assign armNow  = pendAny && !pendRelease;
  assign emitRep = !pendAny && repPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtValid   <= 1'b0;
      evtCode    <= '0;
      evtRelease <= 1'b0;
      repActive  <= 1'b0;
      repPend    <= 1'b0;
      repKey     <= '0;
      lastKey    <= '0;
      repCnt     <= '0;
      phase      <= PH_DELAY;
    end else begin
      // Output register: key changes first, then a waiting repeat.
      evtValid <= pendAny || repPend;
      if (pendAny) begin
        evtCode    <= pendKey;
        evtRelease <= pendRelease;
      end else if (repPend) begin
        evtCode    <= repKey;
        evtRelease <= 1'b0;
      end
      if (emitRep) repPend <= 1'b0;

      // Repeat timer, advanced by the timebase.
      if (repStop) begin
        repActive <= 1'b0;
      end else if (tick && repActive) begin
        if (repFire) begin
          repCnt  <= '0;
          phase   <= PH_RATE;
          repPend <= 1'b1;
          repKey  <= lastKey;
        end else begin
          repCnt <= repInc[REP_W-1:0];
        end
      end

      // A reported press becomes the repeat target and restarts the delay.
      if (armNow) begin
        lastKey   <= pendKey;
        repActive <= repeatEn;
        repCnt    <= '0;
        phase     <= PH_DELAY;
        repPend   <= 1'b0;
      end
    end
  end

  assign repPending = repPend;

endmodule

// File: rtl/static_keymatrix_detector.sv
module static_keymatrix_detector
  import keymx_pkg::*;
#(
  parameter int ROWS        = 8,
  parameter int COLS        = 8,
  parameter int DEB_W       = 4,
  parameter int REP_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NKEYS      = ROWS * COLS,
  localparam int KEY_W      = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NKEYS-1:0] matLevel,
  input  logic             tick,
  input  logic [DEB_W-1:0] debounceTicks,
  input  logic             releaseEn,
  input  logic             repeatEn,
  input  logic [REP_W-1:0] repeatDelay,
  input  logic [REP_W-1:0] repeatRate,
  output logic             evtValid,
  output logic [KEY_W-1:0] evtCode,
  output logic             evtRelease
);

  popStrobe_t       strobe;
  logic [NKEYS-1:0] stableVec;
  logic [NKEYS-1:0] stableNext;
  logic             pendAny;
  logic [KEY_W-1:0] pendKey;
  logic             pendRelease;
  logic             repPending;

  keymx_datapath #(
    .ROWS       (ROWS),
    .COLS       (COLS),
    .DEB_W      (DEB_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .matLevel     (matLevel),
    .tick         (tick),
    .debounceTicks(debounceTicks),
    .releaseEn    (releaseEn),
    .strobe       (strobe),
    .stableVec    (stableVec),
    .stableNext   (stableNext),
    .pendAny      (pendAny),
    .pendKey      (pendKey),
    .pendRelease  (pendRelease)
  );

  keymx_control #(
    .NKEYS(NKEYS),
    .REP_W(REP_W)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .repeatEn   (repeatEn),
    .repeatDelay(repeatDelay),
    .repeatRate (repeatRate),
    .pendAny    (pendAny),
    .pendKey    (pendKey),
    .pendRelease(pendRelease),
    .stableNext (stableNext),
    .strobe     (strobe),
    .evtValid   (evtValid),
    .evtCode    (evtCode),
    .evtRelease (evtRelease),
    .repPending (repPending)
  );

endmodule

// File: rtl/keymx_checker.sv
module keymx_checker #(
  parameter int NKEYS = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [NKEYS-1:0] stableVec,
  input logic             pendAny,
  input logic             repPending,
  input logic             evtValid,
  input logic             evtRelease
);

  p_reset_idle_r8: assert property (@(posedge clk)
    !rstN |=> !evtValid);

  p_settle_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(stableVec));

  p_release_from_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtRelease) |-> $past(pendAny));

  p_pending_drains_r4: assert property (@(posedge clk) disable iff (!rstN)
    pendAny |=> evtValid);

  p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pendAny && !repPending) |=> !evtValid);

  p_repeat_is_press_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !$past(pendAny)) |-> !evtRelease);

endmodule

bind static_keymatrix_detector keymx_checker #(.NKEYS(ROWS * COLS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .stableVec (stableVec),
  .pendAny   (pendAny),
  .repPending(repPending),
  .evtValid  (evtValid),
  .evtRelease(evtRelease)
);

// File: tb/static_keymatrix_detector_tb.sv
module static_keymatrix_detector_tb;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int NK   = ROWS * COLS;
  localparam int MAXE = 80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [NK-1:0] matLevel = '0;
  logic        tick = 1'b0;
  logic [3:0]  debounceTicks = 4'd1;
  logic        releaseEn = 1'b1;
  logic        repeatEn = 1'b0;
  logic [3:0]  repeatDelay = 4'd0;
  logic [3:0]  repeatRate = 4'd0;
  logic        evtValid;
  logic [5:0]  evtCode;
  logic        evtRelease;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // Bench reference state, indexed by key number.
  bit lvl [NK];
  bit refStable [NK];
  int refCnt [NK];
  bit repActive = 0;
  int repCnt = 0;
  bit repPhaseRate = 0;
  int lastKey = 0;

  always #2 clk = ~clk;

  static_keymatrix_detector u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .matLevel     (matLevel),
    .tick         (tick),
    .debounceTicks(debounceTicks),
    .releaseEn    (releaseEn),
    .repeatEn     (repeatEn),
    .repeatDelay  (repeatDelay),
    .repeatRate   (repeatRate),
    .evtValid     (evtValid),
    .evtCode      (evtCode),
    .evtRelease   (evtRelease)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
  endtask

  // Drive a key's line at its row-major position; level back to the settled
  // state restarts its debounce count.
  task automatic setKey(int k, bit v);
    lvl[k] = v;
    if (v == refStable[k]) refCnt[k] = 0;
    @(negedge clk);
    matLevel[(k % ROWS) * COLS + (k / ROWS)] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic doTick(string tag);
    int expCode [MAXE];
    int expRel  [MAXE];
    int gotCode [MAXE];
    int gotRel  [MAXE];
    int gotCyc  [MAXE];
    int nExp;
    int nGot;
    int lim;
    bit anyPress;
    int lastPress;
    bit fire;
    nExp = 0; nGot = 0; anyPress = 0; lastPress = 0; fire = 0;
    lim = (debounceTicks == 0) ? 1 : int'(debounceTicks);
    settle();
    for (int k = 0; k < NK; k++) begin
      if (lvl[k] != refStable[k]) begin
        refCnt[k]++;
        if (refCnt[k] >= lim) begin
          refStable[k] = lvl[k];
          refCnt[k] = 0;
          if (lvl[k]) begin
            expCode[nExp] = k; expRel[nExp] = 0; nExp++;
            anyPress = 1; lastPress = k;
          end else if (releaseEn) begin
            expCode[nExp] = k; expRel[nExp] = 1; nExp++;
          end
        end
      end
    end
    if (repActive) begin
      if (!repeatEn || !refStable[lastKey]) begin
        repActive = 0;
      end else begin
        int rl;
        rl = repPhaseRate ? int'(repeatRate) : int'(repeatDelay);
        if (rl == 0) rl = 1;
        repCnt++;
        if (repCnt >= rl) begin
          fire = 1; repCnt = 0; repPhaseRate = 1;
        end
      end
    end
    if (anyPress) begin
      lastKey = lastPress; repActive = repeatEn; repCnt = 0; repPhaseRate = 0;
    end else if (fire) begin
      expCode[nExp] = lastKey; expRel[nExp] = 0; nExp++;
    end
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int cyc = 1; cyc <= MAXE; cyc++) begin
      @(negedge clk);
      if (evtValid && nGot < MAXE) begin
        gotCode[nGot] = int'(evtCode);
        gotRel[nGot]  = int'(evtRelease);
        gotCyc[nGot]  = cyc;
        nGot++;
      end
    end
    chk(nGot == nExp, tag, "event count", nGot, nExp);
    for (int i = 0; i < nExp; i++) begin
      int a;
      int e;
      e = expCode[i] * 1000 + expRel[i] * 100 + (1 + i);
      a = (i < nGot) ? gotCode[i] * 1000 + gotRel[i] * 100 + gotCyc[i] : -1;
      chk(a == e, tag, "event code*1000+release*100+cycle (R5 timing)", a, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    bit quiet;
    for (int k = 0; k < NK; k++) begin
      lvl[k] = 0; refStable[k] = 0; refCnt[k] = 0;
    end
    quiet = 1;
    repeat (5) begin
      @(negedge clk);
      if (evtValid) quiet = 0;
    end
    rstN = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (evtValid) quiet = 0;
    end
    chk(quiet, "R8", "evtValid during and after reset", int'(!quiet), 0);
    doTick("R8");

    // R1: every row/column position, press then release.
    debounceTicks = 4'd1; releaseEn = 1'b1; repeatEn = 1'b0;
    for (int k = 0; k < NK; k++) begin
      setKey(k, 1); doTick("R1");
      setKey(k, 0); doTick("R1");
    end

    // R2: window length, bounce restart, zero field.
    debounceTicks = 4'd3;
    setKey(20, 1); doTick("R2"); doTick("R2"); doTick("R2");
    setKey(20, 0); doTick("R2"); doTick("R2");
    setKey(20, 1); setKey(20, 0);
    doTick("R2"); doTick("R2"); doTick("R2");
    debounceTicks = 4'd0;
    setKey(45, 1); doTick("R2");
    setKey(45, 0); doTick("R2");

    // R3: release reporting gated.
    debounceTicks = 4'd1; releaseEn = 1'b0;
    setKey(33, 1); doTick("R3");
    setKey(33, 0); doTick("R3");
    releaseEn = 1'b1;
    setKey(33, 1); doTick("R3");
    setKey(33, 0); doTick("R3");

    // R4: many keys in one tick, mixed presses and releases.
    for (int k = 0; k < NK; k++) if (k % 3 == 0) setKey(k, 1);
    doTick("R4");
    for (int k = 0; k < NK; k++) setKey(k, (k % 2) == 1);
    doTick("R4");
    for (int k = 0; k < NK; k++) setKey(k, 0);
    doTick("R4");

    // R6: held key repeats after delay, then at rate.
    repeatEn = 1'b1; repeatDelay = 4'd3; repeatRate = 4'd2;
    setKey(10, 1); doTick("R6");
    repeat (9) doTick("R6");
    setKey(10, 0); doTick("R6");
    repeat (3) doTick("R6");

    // R7: retarget to a newer lower key, stop on unreported release.
    setKey(40, 1); doTick("R7");
    repeat (2) doTick("R7");
    setKey(7, 1); doTick("R7");
    repeat (5) doTick("R7");
    releaseEn = 1'b0;
    setKey(7, 0); doTick("R7");
    repeat (4) doTick("R7");
    releaseEn = 1'b1;
    setKey(40, 0); doTick("R7");
    // R7: disabling mid-hold stops repeats.
    setKey(50, 1); doTick("R7");
    repeat (4) doTick("R7");
    repeatEn = 1'b0;
    repeat (3) doTick("R7");
    setKey(50, 0); doTick("R7");
    // R6: zero delay and rate repeat on every tick.
    repeatEn = 1'b1; repeatDelay = 4'd0; repeatRate = 4'd0;
    setKey(3, 1); doTick("R6");
    repeat (4) doTick("R6");
    setKey(3, 0); doTick("R6");
    doTick("R6");

    summary();
    $finish;
  end

endmodule